// File: doc/BRIEF.md
# Auxiliary Memory Block-Copy Engine

This block copies blocks of 32-bit words between a main memory and an auxiliary memory. Software sets it up through a small register file: a main-memory pointer, an auxiliary-memory pointer, and a count word. The count word holds the copy direction and the byte length. Each of these three registers can be written as a whole 32-bit word or as two separate 16-bit halves.

The engine is armed only once both halves of the count word have been written since the previous start. It then moves one word per accepted memory handshake until the length runs out. At the end it clears the length, sets a sticky completion flag and, if the flag is unmasked, raises an interrupt.

A read of the auxiliary memory beyond its end produces zeros. A write into the auxiliary memory beyond its end is refused silently. Three further registers only answer the bus: a size register, a mode register and a refresh register.

Top module: `aux_dma`

## Requirements
- R1: The register offsets on `reg_addr` are as follows. The main pointer is 0 (high half), 1 (low half) and 6 (whole word). The auxiliary pointer is 2, 3 and 7. The count is 4, 5 and 8. A high-half write replaces bits 31:16 and keeps bits 15:0. A low-half write replaces bits 15:0 and keeps bits 31:16. Every view reads back the current value, with a half placed in bits 15:0.
- R2: Writing the count high half sets one arm flag, and writing the low half sets the other. A whole-word count write sets both flags. A copy starts only when both flags are set, and starting clears both flags, so writing a single half afterwards starts nothing.
- R3: When count bit 31 is 0, words are copied from main memory to auxiliary memory. The length is count bits 30:0, in bytes.
- R4: When count bit 31 is 1, words are copied from auxiliary memory to main memory.
- R5: Before use, the main pointer is reduced modulo 2^MAIN_AW. The register itself keeps all 32 bits.
- R6: Take an auxiliary pointer of 2^AUX_AW or above. With direction 1, the block writes zeros to main memory for the full length and then completes normally.
- R7: Take an auxiliary pointer of 2^AUX_AW or above. With direction 0, no memory access takes place, the count keeps its value and the completion flag stays clear.
- R8: On completion, count bits 30:0 become 0 and bit 31 keeps its value. The completion flag (bit 0 at offset 12) is set.
- R9: At offset 12, bit 0 is the completion flag and is cleared by writing 1. Bit 1 is a read/write mask. `irq` is high exactly while both bits are 1.
- R10: Offset 9 returns the low 16 bits of the last value written to it. Offset 10 always reads 1 and ignores writes. Offset 11 always reads 0 and ignores writes.
- R11: `busy` is high from the moment the count is armed until the copy ends. Register writes made while `busy` is high have no effect.
- R12: After reset, all registers, both arm flags, the mask and the completion flag are 0, and `irq` and `busy` are low.
- R13: Each word moves through one read handshake on the source port and then one write handshake on the destination port. Only one port requests at a time. A request holds its address until acknowledged. Both pointers advance by 4 per word, and a length of L bytes takes L/4 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| busy | output | 1 | Copy armed or in progress |
| irq | output | 1 | Completion interrupt |
| mm_req | output | 1 | Main memory request |
| mm_we | output | 1 | Main memory write enable |
| mm_addr | output | MAIN_AW | Main memory byte address |
| mm_wdata | output | 32 | Main memory write data |
| mm_rdata | input | 32 | Main memory read data, valid with ack |
| mm_ack | input | 1 | Main memory acknowledge |
| ax_req | output | 1 | Auxiliary memory request |
| ax_we | output | 1 | Auxiliary memory write enable |
| ax_addr | output | AUX_AW | Auxiliary memory byte address |
| ax_wdata | output | 32 | Auxiliary memory write data |
| ax_rdata | input | 32 | Auxiliary memory read data, valid with ack |
| ax_ack | input | 1 | Auxiliary memory acknowledge |

## Verification
The hardest state to reach from the ports is the arm logic when only part of the count has been written. One flag is set, the block must stay idle with no memory traffic, and a later single-half write must still not start a copy once a finished copy has cleared both flags. The bench reaches this state by writing only the count high half, waiting and comparing both memories against shadow copies. It then completes the arming with the low half, and after that copy it writes the low half alone again.

A sweep over direction, pointer offsets, lengths, half-versus-whole count writes and out-of-range auxiliary pointers checks every word of both memories after each copy.

// File: rtl/aux_dma.sv
module aux_dma #(
  parameter int MAIN_AW = 16,
  parameter int AUX_AW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               busy,
  output logic               irq,
  output logic               mm_req,
  output logic               mm_we,
  output logic [MAIN_AW-1:0] mm_addr,
  output logic [31:0]        mm_wdata,
  input  logic [31:0]        mm_rdata,
  input  logic               mm_ack,
  output logic               ax_req,
  output logic               ax_we,
  output logic [AUX_AW-1:0]  ax_addr,
  output logic [31:0]        ax_wdata,
  input  logic [31:0]        ax_rdata,
  input  logic               ax_ack
);
  localparam logic [3:0] A_MHI = 4'd0, A_MLO = 4'd1, A_XHI = 4'd2, A_XLO = 4'd3,
                         A_CHI = 4'd4, A_CLO = 4'd5, A_MW  = 4'd6, A_XW  = 4'd7,
                         A_CW  = 4'd8, A_SZ  = 4'd9, A_MODE = 4'd10, A_RFSH = 4'd11,
                         A_CTL = 4'd12;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  state_t st;

  logic [31:0]        mptr_q, xptr_q, cnt_q;
  logic [15:0]        size_q;
  logic               arm_hi, arm_lo, done_q, mask_q, zfill;
  logic [MAIN_AW-1:0] mp;
  logic [AUX_AW-1:0]  xp;
  logic [30:0]        rem;
  logic [31:0]        buf_q;

  wire dir     = cnt_q[31];
  wire aux_oob = |xptr_q[31:AUX_AW];
  wire armed   = arm_hi & arm_lo;
  wire wr_ok   = reg_wr & ~busy;
  wire src_ack = dir ? ax_ack : mm_ack;
  wire dst_ack = dir ? mm_ack : ax_ack;
  wire last    = rem <= 31'd4;

  assign busy = (st != S_IDLE) | armed;
  assign irq  = done_q & mask_q;

  assign mm_req   = (st == S_RD & ~dir) | (st == S_WR & dir);
  assign mm_we    = st == S_WR;
  assign mm_addr  = mp;
  assign mm_wdata = zfill ? 32'd0 : buf_q;
  assign ax_req   = (st == S_RD & dir) | (st == S_WR & ~dir);
  assign ax_we    = st == S_WR;
  assign ax_addr  = xp;
  assign ax_wdata = buf_q;

  always_comb begin
    case (reg_addr)
      A_MHI:   reg_rdata = {16'd0, mptr_q[31:16]};
      A_MLO:   reg_rdata = {16'd0, mptr_q[15:0]};
      A_XHI:   reg_rdata = {16'd0, xptr_q[31:16]};
      A_XLO:   reg_rdata = {16'd0, xptr_q[15:0]};
      A_CHI:   reg_rdata = {16'd0, cnt_q[31:16]};
      A_CLO:   reg_rdata = {16'd0, cnt_q[15:0]};
      A_MW:    reg_rdata = mptr_q;
      A_XW:    reg_rdata = xptr_q;
      A_CW:    reg_rdata = cnt_q;
      A_SZ:    reg_rdata = {16'd0, size_q};
      A_MODE:  reg_rdata = 32'd1;
      A_RFSH:  reg_rdata = 32'd0;
      A_CTL:   reg_rdata = {30'd0, mask_q, done_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mptr_q <= '0; xptr_q <= '0; cnt_q <= '0; size_q <= '0;
      arm_hi <= 1'b0; arm_lo <= 1'b0; done_q <= 1'b0; mask_q <= 1'b0;
      zfill <= 1'b0; mp <= '0; xp <= '0; rem <= '0; buf_q <= '0;
      st <= S_IDLE;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          A_MHI: mptr_q[31:16] <= reg_wdata[15:0];
          A_MLO: mptr_q[15:0]  <= reg_wdata[15:0];
          A_XHI: xptr_q[31:16] <= reg_wdata[15:0];
          A_XLO: xptr_q[15:0]  <= reg_wdata[15:0];
          A_CHI: begin cnt_q[31:16] <= reg_wdata[15:0]; arm_hi <= 1'b1; end
          A_CLO: begin cnt_q[15:0]  <= reg_wdata[15:0]; arm_lo <= 1'b1; end
          A_MW:  mptr_q <= reg_wdata;
          A_XW:  xptr_q <= reg_wdata;
          A_CW:  begin cnt_q <= reg_wdata; arm_hi <= 1'b1; arm_lo <= 1'b1; end
          A_SZ:  size_q <= reg_wdata[15:0];
          A_CTL: begin
            mask_q <= reg_wdata[1];
            if (reg_wdata[0]) done_q <= 1'b0;
          end
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (armed) begin
          arm_hi <= 1'b0;
          arm_lo <= 1'b0;
          if (!(aux_oob && !dir)) begin
            if (cnt_q[30:0] == 31'd0) begin
              done_q <= 1'b1;
            end else begin
              mp    <= mptr_q[MAIN_AW-1:0];
              xp    <= xptr_q[AUX_AW-1:0];
              rem   <= cnt_q[30:0];
              zfill <= aux_oob;
              st    <= aux_oob ? S_WR : S_RD;
            end
          end
        end
        S_RD: if (src_ack) begin
          buf_q <= dir ? ax_rdata : mm_rdata;
          st    <= S_WR;
        end
        S_WR: if (dst_ack) begin
          mp <= mp + MAIN_AW'(4);
          xp <= xp + AUX_AW'(4);
          if (last) begin
            cnt_q[30:0] <= '0;
            done_q      <= 1'b1;
            zfill       <= 1'b0;
            st          <= S_IDLE;
          end else begin
            rem <= rem - 31'd4;
            st  <= zfill ? S_WR : S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_dma_chk.sv
module aux_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_rdata,
  input logic        busy,
  input logic        irq,
  input logic        mm_req,
  input logic        mm_ack,
  input logic        ax_req,
  input logic        ax_ack
);
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) !(mm_req && ax_req)); // R13
  AST_MM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mm_req && !mm_ack) |=> mm_req); // R13
  AST_AX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ax_req && !ax_ack) |=> ax_req); // R13
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mm_req || ax_req) |-> busy); // R11
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> $past(reg_wr)); // R9
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(busy) || $past(reg_wr))); // R8
  AST_MODE_ONE: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == 4'd10) |-> (reg_rdata == 32'd1)); // R10
endmodule

bind aux_dma aux_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .busy(busy), .irq(irq), .mm_req(mm_req), .mm_ack(mm_ack), .ax_req(ax_req), .ax_ack(ax_ack)
);

// File: tb/aux_dma_test.sv
`timescale 1ns/1ps
module aux_dma_test;
  localparam int MAW = 10, XAW = 10, NW = 256;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic busy, irq, mm_req, mm_we, ax_req, ax_we;
  logic [MAW-1:0] mm_addr;
  logic [XAW-1:0] ax_addr;
  logic [31:0] mm_wdata, ax_wdata, mm_rdata = '0, ax_rdata = '0;
  logic mm_ack = 1'b0, ax_ack = 1'b0, fill = 1'b0;
  logic [31:0] mmem [NW], amem [NW], exp_m [NW], exp_a [NW];
  int checks = 0, errors = 0, mm_hs = 0, cyc = 0;

  always #2 clk = ~clk;

  aux_dma #(.MAIN_AW(MAW), .AUX_AW(XAW)) uut (.*);

  function automatic logic [31:0] mpat(int i); return 32'hA500_0000 | (i * 32'h0001_0203); endfunction
  function automatic logic [31:0] apat(int i); return 32'h5A00_0000 ^ (i * 32'h0103_0507); endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fill) for (int i = 0; i < NW; i++) begin mmem[i] <= mpat(i); amem[i] <= apat(i); end
    if (mm_req && !mm_ack) begin
      mm_ack <= 1'b1; mm_hs <= mm_hs + 1;
      if (mm_we) mmem[mm_addr[MAW-1:2]] <= mm_wdata; else mm_rdata <= mmem[mm_addr[MAW-1:2]];
    end else mm_ack <= 1'b0;
    if (ax_req && !ax_ack) begin
      ax_ack <= 1'b1;
      if (ax_we) amem[ax_addr[XAW-1:2]] <= ax_wdata; else ax_rdata <= amem[ax_addr[XAW-1:2]];
    end else ax_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %h expected %h", req, act, exp); end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < NW; i++) if (bad < 0 && (mmem[i] !== exp_m[i] || amem[i] !== exp_a[i])) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, (mmem[bad] !== exp_m[bad]) ? mmem[bad] : amem[bad],
             (mmem[bad] !== exp_m[bad]) ? exp_m[bad] : exp_a[bad]);
  endtask

  task automatic xfer(input bit dir, input logic [31:0] ma, input logic [31:0] xa, input int len,
                      input bit whole, input string req);
    logic [31:0] v;
    int h0, mi, xi;
    bit oob;
    oob = xa >= (32'd1 << XAW);
    wr(4'd12, 32'd1);
    wr(4'd6, ma); wr(4'd7, xa);
    h0 = mm_hs;
    if (whole) wr(4'd8, {dir, 31'(len)});
    else begin wr(4'd4, {16'd0, dir, 15'd0}); wr(4'd5, 32'(len)); end
    wait_idle();
    mi = int'(ma[MAW-1:2]); xi = int'(xa[XAW-1:2]);
    if (!(oob && !dir))
      for (int k = 0; k < len / 4; k++)
        if (dir) exp_m[(mi + k) % NW] = oob ? 32'd0 : exp_a[(xi + k) % NW];
        else exp_a[(xi + k) % NW] = exp_m[(mi + k) % NW];
    cmp_mem(req);
    rd(4'd8, v);
    chk(v == ((oob && !dir) ? {dir, 31'(len)} : {dir, 31'd0}), "R8 count after copy", v,
        (oob && !dir) ? {dir, 31'(len)} : {dir, 31'd0});
    rd(4'd12, v);
    chk(v[0] == !(oob && !dir), "R8 completion flag", v, 32'(!(oob && !dir)));
    chk(mm_hs - h0 == ((oob && !dir) ? 0 : len / 4), "R13 main handshakes", mm_hs - h0, (oob && !dir) ? 0 : len / 4);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors++; $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NW; i++) begin exp_m[i] = mpat(i); exp_a[i] = apat(i); end
    fill = 1'b1;
    repeat (3) @(negedge clk);
    fill = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int a = 0; a < 13; a++) begin
      rd(4'(a), v);
      chk(v == ((a == 10) ? 32'd1 : 32'd0), "R12 reset register", v, (a == 10) ? 32'd1 : 32'd0);
    end
    chk(!busy && !irq, "R12 busy/irq low", {busy, irq}, 0);
    // R1 halves and aliases
    wr(4'd0, 32'hFFFF_1234); wr(4'd1, 32'hFFFF_5678);
    rd(4'd6, v); chk(v == 32'h1234_5678, "R1 main halves", v, 32'h1234_5678);
    wr(4'd7, 32'hAAAA_BBBB); wr(4'd2, 32'h0000_0C0D);
    rd(4'd7, v); chk(v == 32'h0C0D_BBBB, "R1 aux high keeps low", v, 32'h0C0D_BBBB);
    wr(4'd3, 32'h0000_1111);
    rd(4'd3, v); chk(v == 32'h0000_1111, "R1 aux low readback", v, 32'h1111);
    rd(4'd2, v); chk(v == 32'h0000_0C0D, "R1 aux high readback", v, 32'h0C0D);
    // R10 side registers
    wr(4'd9, 32'hBEEF_5A5A); rd(4'd9, v); chk(v == 32'h5A5A, "R10 size readback", v, 32'h5A5A);
    wr(4'd10, 32'h0); rd(4'd10, v); chk(v == 32'd1, "R10 mode reads 1", v, 1);
    wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, v); chk(v == 32'd0, "R10 refresh reads 0", v, 0);
    // R2 partial arm
    wr(4'd12, 32'd1); wr(4'd6, 32'h40); wr(4'd7, 32'h80);
    wr(4'd4, 32'h0);
    repeat (10) @(negedge clk);
    chk(!busy, "R2 one half does not start", busy, 0);
    cmp_mem("R2 no traffic on one half");
    wr(4'd5, 32'd64);
    chk(busy, "R11 busy after arm", busy, 1);
    wr(4'd6, 32'hDEAD_BEEF);
    wait_idle();
    for (int k = 0; k < 16; k++) exp_a[(32 + k) % NW] = exp_m[(16 + k) % NW];
    cmp_mem("R3 copy after second half");
    rd(4'd6, v); chk(v == 32'h40, "R11 write while busy ignored", v, 32'h40);
    wr(4'd12, 32'd1);
    wr(4'd5, 32'd64);
    repeat (10) @(negedge clk);
    rd(4'd12, v); chk(v[0] == 1'b0 && !busy, "R2 flags cleared by start", v, 0);
    cmp_mem("R2 no re-arm from one half");
    // R9 interrupt
    wr(4'd8, 32'd32); wait_idle();
    for (int k = 0; k < 8; k++) exp_a[(32 + k) % NW] = exp_m[(16 + k) % NW];
    chk(!irq, "R9 masked irq low", irq, 0);
    wr(4'd12, 32'd2); chk(irq, "R9 unmasked irq high", irq, 1);
    wr(4'd12, 32'd3); chk(!irq, "R9 write-1 clears flag", irq, 0);
    rd(4'd12, v); chk(v == 32'd2, "R9 control readback", v, 2);
    wr(4'd12, 32'd0);
    // R3/R4/R13 sweep
    for (int d = 0; d < 2; d++)
      for (int mi = 0; mi < 3; mi++)
        for (int xi = 0; xi < 3; xi++)
          xfer(d[0], 32'(mi * 32'h120), 32'(xi * 32'h1A0), 32 * (1 + (mi + xi) % 3), ((mi + xi) % 2) == 1,
               d ? "R4 aux to main" : "R3 main to aux");
    // R5 main pointer masking
    xfer(1'b0, 32'h0000_1040, 32'h100, 32, 1'b1, "R5 main pointer masked");
    xfer(1'b1, 32'hFFF0_0000, 32'h200, 32, 1'b0, "R5 main pointer masked high");
    // R6 / R7 out of range
    xfer(1'b1, 32'h80, 32'h400, 64, 1'b1, "R6 zero fill");
    xfer(1'b1, 32'h300, 32'h8000_0000, 32, 1'b0, "R6 zero fill far");
    xfer(1'b0, 32'h80, 32'h400, 64, 1'b1, "R7 refused write");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule